// File: doc/BRIEF.md
# Receive DMA Read Channel Port

This block passes received message bytes from one of eight per-channel receive buffers out to an external DMA controller over an asynchronous, microprocessor-style bus. A configuration register picks the served channel and the strobe style, turns the interface on, and can restart the transfer state machine. The block asks for service by pulling an active-low request line low, but only once the selected buffer holds a whole message. The controller answers with an active-low acknowledge and then fetches one byte per strobe pulse.

Two strobe styles exist. In read-strobe style the RD pin itself is the byte strobe. In direction style RD tells the direction of the cycle and WR is the byte strobe. The strobe and acknowledge pins are asynchronous, so they pass through two-flop synchronizers. The head byte of the selected buffer is popped when a qualifying strobe is released. After the byte that carries the end-of-message marker, the request goes high again.

Top module: `rxdma_rd_port`

## Requirements
- R1: The configuration register resets to 0x00 and reads back as {restart bit 7, enable bit 6, strobe style bit 5, 2'b00, channel bits 2..0}. Bits 4..3 always read 0.
- R2: Writing the restart bit (bit 7) while it holds 0 drops the request within one cycle and abandons the transfer. Writing it again while it already holds 1, or writing it to 0, leaves a transfer in progress undisturbed.
- R3: While the enable bit is 0, the request line stays high and no buffer is popped.
- R4: While enabled, the request goes low only if the selected channel flags a complete message. A buffer with data but no complete message raises no request.
- R5: With strobe style bit 5 = 0, every low pulse of RD while acknowledge is low presents the selected channel's head byte. The buffer is popped once as RD returns high.
- R6: With strobe style bit 5 = 1, WR is the byte strobe and RD = 1 marks a read cycle. Each low WR pulse during a read cycle with acknowledge low presents and pops one byte.
- R7: data_oe is 1 only while the request is low, acknowledge is low and the active strobe is low (and, in direction style, RD = 1). Strobes with acknowledge high, or WR pulses with RD = 0 in direction style, present nothing and pop nothing.
- R8: Popping a byte whose end-of-message flag is set returns the request high. If another complete message is waiting, the request falls again.
- R9: Writing the enable bit to 0 during a transfer drops the request within one cycle. Later strobes pop nothing.
- R10: The channel field is plain binary (0..7) and selects which buffer is served. A new value written while a request is outstanding takes effect only after that message ends.
- R11: At most one buffer pop line is high in any cycle, only the served channel's line, and exactly one pop per qualifying strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| dma_req_n | output | 1 | Active-low transfer request |
| dma_ack_n | input | 1 | Active-low acknowledge from controller |
| rd_n | input | 1 | Read strobe or direction (1 = read) |
| wr_n | input | 1 | Write strobe, byte strobe in direction style |
| data_out | output | 8 | Byte presented to the bus |
| data_oe | output | 1 | Bus output enable |
| buf_pop | output | NCH | Per-channel head-byte pop |
| buf_data | input | NCH*8 | Per-channel head byte |
| buf_eom | input | NCH | Head byte ends a message |
| buf_msg_ready | input | NCH | Channel holds a complete message |

## Verification
A wrong transfer state shows as a request that falls without a complete message, or that stays low after an end-of-message pop. A wrong held channel shows as bytes or pops from the wrong buffer. Because the strobe pins are synchronized, the effect on data_oe appears two cycles after a pin change, and a pop three cycles after it. The bench therefore samples four cycles after each pin edge and counts pops per channel. An edge detector that fires on level, or twice per pulse, shows as a pop count that differs from the expected count.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int CFG_W   = 8;
  localparam int CHW     = 3;
  localparam int BIT_RST = 7;
  localparam int BIT_EN  = 6;
  localparam int BIT_DIR = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } xfer_st_e;
endpackage

// File: rtl/rxdma_sync2.sv
module rxdma_sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rxdma_cfg_reg.sv
module rxdma_cfg_reg
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             en,
  output logic             dir_mode,
  output logic [CHW-1:0]   chan,
  output logic             restart_pulse,
  output logic             disable_now
);
  logic           rst_q, rst_d;
  logic           en_q, en_d;
  logic           dir_q, dir_d;
  logic [CHW-1:0] chan_q, chan_d;

  always_comb begin
    rst_d  = rst_q;
    en_d   = en_q;
    dir_d  = dir_q;
    chan_d = chan_q;
    if (we) begin
      rst_d  = wdata[BIT_RST];
      en_d   = wdata[BIT_EN];
      dir_d  = wdata[BIT_DIR];
      chan_d = wdata[CHW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      chan_q <= '0;
    end else if (we) begin
      rst_q  <= rst_d;
      en_q   <= en_d;
      dir_q  <= dir_d;
      chan_q <= chan_d;
    end
  end

  assign restart_pulse = we & wdata[BIT_RST] & ~rst_q;
  assign disable_now   = we & ~wdata[BIT_EN];
  assign en            = en_q;
  assign dir_mode      = dir_q;
  assign chan          = chan_q;
  assign rdata         = {rst_q, en_q, dir_q, {(CFG_W-CHW-3){1'b0}}, chan_q};
endmodule

// File: rtl/rxdma_chan_mux.sv
module rxdma_chan_mux
  import rxdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic [CHW-1:0]    sel,
  input  logic              pop_evt,
  input  logic [NCH*DW-1:0] buf_data,
  input  logic [NCH-1:0]    buf_eom,
  input  logic [NCH-1:0]    buf_msg_ready,
  output logic [DW-1:0]     data_sel,
  output logic              eom_sel,
  output logic              ready_sel,
  output logic [NCH-1:0]    buf_pop
);
  logic [NCH-1:0] hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit[g]     = (sel == CHW'(g));
    assign buf_pop[g] = hit[g] & pop_evt;
  end

  always_comb begin
    data_sel  = '0;
    eom_sel   = 1'b0;
    ready_sel = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) begin
        data_sel  = buf_data[i*DW +: DW];
        eom_sel   = buf_eom[i];
        ready_sel = buf_msg_ready[i];
      end
    end
  end
endmodule

// File: rtl/rxdma_xfer_ctrl.sv
module rxdma_xfer_ctrl
  import rxdma_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           dir_mode,
  input  logic [CHW-1:0] cfg_chan,
  input  logic           abort,
  input  logic           ready_sel,
  input  logic           eom_sel,
  input  logic           rd_s,
  input  logic           wr_s,
  input  logic           ack_s,
  output logic [CHW-1:0] sel_ch,
  output logic [CHW-1:0] held_ch,
  output logic           pop_evt,
  output logic           data_oe,
  output logic           req_n
);
  xfer_st_e       state_q, state_d;
  logic [CHW-1:0] held_q;
  logic           qual_prev_q;
  logic           str_act, in_xfer, qual;

  assign in_xfer = (state_q == ST_XFER);
  assign str_act = dir_mode ? (~wr_s & rd_s) : ~rd_s;
  assign qual    = in_xfer & ~ack_s & str_act;
  assign pop_evt = qual_prev_q & ~str_act & ~ack_s & in_xfer & ~abort;
  assign sel_ch  = in_xfer ? held_q : cfg_chan;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (en && ready_sel && !abort) state_d = ST_XFER;
      ST_XFER: begin
        if (abort || !en)          state_d = ST_IDLE;
        else if (pop_evt && eom_sel) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      held_q      <= '0;
      qual_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      held_q      <= sel_ch;
      qual_prev_q <= qual;
    end
  end

  assign data_oe = qual;
  assign req_n   = ~in_xfer;
  assign held_ch = held_q;
endmodule

// File: rtl/rxdma_rd_port.sv
module rxdma_rd_port
  import rxdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              dma_req_n,
  input  logic              dma_ack_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [DW-1:0]     data_out,
  output logic              data_oe,
  output logic [NCH-1:0]    buf_pop,
  input  logic [NCH*DW-1:0] buf_data,
  input  logic [NCH-1:0]    buf_eom,
  input  logic [NCH-1:0]    buf_msg_ready
);
  logic [1:0]     rs_q;
  logic           rst_int_n;
  logic           en, dir_mode, restart_pulse, disable_now;
  logic [CHW-1:0] cfg_chan, sel_ch, held_ch;
  logic [2:0]     pins_s;
  logic           rd_s, wr_s, ack_s;
  logic           ready_sel, eom_sel, pop_evt;
  logic [DW-1:0]  data_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  rxdma_sync2 #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({dma_ack_n, wr_n, rd_n}), .q(pins_s)
  );
  assign rd_s  = pins_s[0];
  assign wr_s  = pins_s[1];
  assign ack_s = pins_s[2];

  rxdma_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en(en), .dir_mode(dir_mode), .chan(cfg_chan),
    .restart_pulse(restart_pulse), .disable_now(disable_now)
  );

  rxdma_xfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .en(en), .dir_mode(dir_mode),
    .cfg_chan(cfg_chan), .abort(restart_pulse | disable_now),
    .ready_sel(ready_sel), .eom_sel(eom_sel),
    .rd_s(rd_s), .wr_s(wr_s), .ack_s(ack_s),
    .sel_ch(sel_ch), .held_ch(held_ch), .pop_evt(pop_evt),
    .data_oe(data_oe), .req_n(dma_req_n)
  );

  rxdma_chan_mux #(.NCH(NCH), .DW(DW)) u_mux (
    .sel(sel_ch), .pop_evt(pop_evt), .buf_data(buf_data),
    .buf_eom(buf_eom), .buf_msg_ready(buf_msg_ready),
    .data_sel(data_sel), .eom_sel(eom_sel), .ready_sel(ready_sel),
    .buf_pop(buf_pop)
  );

  assign data_out = data_oe ? data_sel : '0;
endmodule

// File: rtl/rxdma_rd_port_chk.sv
module rxdma_rd_port_chk
  import rxdma_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dma_req_n,
  input logic           data_oe,
  input logic [NCH-1:0] buf_pop,
  input logic           en,
  input logic           ack_s,
  input logic           ready_sel,
  input logic           eom_sel,
  input logic [CHW-1:0] held_ch
);
  p_oe_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !dma_req_n);

  p_oe_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !ack_s);

  p_pop_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_pop));

  p_pop_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|buf_pop) |-> !dma_req_n);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> dma_req_n);

  p_req_needs_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req_n) |-> $past(ready_sel));

  p_eom_drops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|buf_pop) && eom_sel) |=> dma_req_n);

  p_chan_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req_n && $past(!dma_req_n)) |-> $stable(held_ch));
endmodule

bind rxdma_rd_port rxdma_rd_port_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .dma_req_n(dma_req_n), .data_oe(data_oe),
  .buf_pop(buf_pop), .en(en), .ack_s(ack_s), .ready_sel(ready_sel),
  .eom_sel(eom_sel), .held_ch(held_ch)
);

// File: tb/tb_rxdma_rd_port.sv
`timescale 1ns/1ps
module tb_rxdma_rd_port;
  localparam int NCH = 8;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [7:0]        cfg_wdata;
  logic [7:0]        cfg_rdata;
  logic              dma_req_n, dma_ack_n, rd_n, wr_n;
  logic [DW-1:0]     data_out;
  logic              data_oe;
  logic [NCH-1:0]    buf_pop;
  logic [NCH*DW-1:0] buf_data;
  logic [NCH-1:0]    buf_eom, buf_msg_ready;

  int checks = 0;
  int fails  = 0;
  logic [4:0] m_idx [NCH];
  int m_len  [NCH];
  int m_left [NCH];
  int pops   [NCH];
  int req_rises = 0;
  logic req_prev = 1'b1;

  always #2.5 clk = ~clk;

  rxdma_rd_port #(.NCH(NCH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dma_req_n(dma_req_n), .dma_ack_n(dma_ack_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_out(data_out), .data_oe(data_oe),
    .buf_pop(buf_pop), .buf_data(buf_data), .buf_eom(buf_eom),
    .buf_msg_ready(buf_msg_ready)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_buf
    assign buf_data[g*DW +: DW] = {3'(g), m_idx[g]};
    assign buf_eom[g]           = (int'(m_idx[g]) == m_len[g] - 1);
    assign buf_msg_ready[g]     = (m_left[g] > 0);
  end

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (buf_pop[c]) begin
        pops[c] = pops[c] + 1;
        if (int'(m_idx[c]) == m_len[c] - 1) begin
          m_idx[c]  = 5'd0;
          m_left[c] = m_left[c] - 1;
        end else begin
          m_idx[c] = m_idx[c] + 5'd1;
        end
      end
    end
    if (dma_req_n && !req_prev) req_rises = req_rises + 1;
    req_prev = dma_req_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int ch, input int len, input int left);
    m_idx[ch]  = 5'd0;
    m_len[ch]  = len;
    m_left[ch] = left;
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One strobe pulse; dir selects direction style (WR strobe, RD high = read)
  task automatic strobe(input bit dir, input int ch, input int k, input bit exp_oe, input string tag);
    int p0;
    p0 = pops[ch];
    if (dir) begin rd_n = 1'b1; wr_n = 1'b0; end
    else     begin rd_n = 1'b0; end
    wait_clk(4);
    chk(data_oe == exp_oe, {tag, " oe"}, int'(data_oe), int'(exp_oe));
    if (exp_oe)
      chk(data_out == {3'(ch), 5'(k)}, {tag, " data"}, int'(data_out), int'({3'(ch), 5'(k)}));
    rd_n = 1'b1; wr_n = 1'b1;
    wait_clk(4);
    chk(pops[ch] == p0 + (exp_oe ? 1 : 0), {tag, " pop count"}, pops[ch], p0 + (exp_oe ? 1 : 0));
  endtask

  task automatic t_reset;
    chk(dma_req_n == 1'b1, "R1 reset req_n", int'(dma_req_n), 1);
    chk(data_oe == 1'b0, "R1 reset oe", int'(data_oe), 0);
    chk(buf_pop == '0, "R1 reset pop", int'(buf_pop), 0);
    chk(cfg_rdata == 8'h00, "R1 reset cfg", int'(cfg_rdata), 0);
  endtask

  task automatic t_cfg_fields;
    cfg_write(8'hFF);
    chk(cfg_rdata == 8'hE7, "R1 readback", int'(cfg_rdata), 'hE7);
    cfg_write(8'h00);
    chk(cfg_rdata == 8'h00, "R1 clear", int'(cfg_rdata), 0);
  endtask

  task automatic t_disabled;
    load(0, 2, 1);
    cfg_write(8'h00);
    dma_ack_n = 1'b0;
    wait_clk(20);
    chk(dma_req_n == 1'b1, "R3 disabled req_n", int'(dma_req_n), 1);
    strobe(1'b0, 0, 0, 1'b0, "R3 strobe while disabled");
    dma_ack_n = 1'b1;
    m_left[0] = 0;
  endtask

  task automatic t_partial;
    load(1, 3, 0);
    cfg_write(8'h41);
    wait_clk(20);
    chk(dma_req_n == 1'b1, "R4 partial no req", int'(dma_req_n), 1);
    m_left[1] = 1;
    wait_clk(3);
    chk(dma_req_n == 1'b0, "R4 complete req", int'(dma_req_n), 0);
    dma_ack_n = 1'b0;
    for (int k = 0; k < 3; k++) strobe(1'b0, 1, k, 1'b1, "R5 rd strobe");
    chk(dma_req_n == 1'b1, "R8 eom req high", int'(dma_req_n), 1);
    dma_ack_n = 1'b1;
  endtask

  task automatic t_ack_gate;
    load(2, 2, 1);
    cfg_write(8'h42);
    wait_clk(3);
    strobe(1'b0, 2, 0, 1'b0, "R7 ack high");
    dma_ack_n = 1'b0;
    strobe(1'b0, 2, 0, 1'b1, "R5 byte0");
    strobe(1'b0, 2, 1, 1'b1, "R5 byte1");
    chk(dma_req_n == 1'b1, "R8 after eom", int'(dma_req_n), 1);
    dma_ack_n = 1'b1;
  endtask

  task automatic t_dir_mode;
    int p0;
    load(5, 2, 1);
    cfg_write(8'h65);
    wait_clk(3);
    dma_ack_n = 1'b0;
    // WR strobe with RD low marks a write cycle: nothing presented
    p0 = pops[5];
    rd_n = 1'b0; wr_n = 1'b0;
    wait_clk(4);
    chk(data_oe == 1'b0, "R7 dir write cycle oe", int'(data_oe), 0);
    wr_n = 1'b1;
    wait_clk(4);
    rd_n = 1'b1;
    wait_clk(4);
    chk(pops[5] == p0, "R7 dir write cycle pop", pops[5], p0);
    // RD low alone is not a strobe in direction style
    rd_n = 1'b0;
    wait_clk(4);
    chk(data_oe == 1'b0, "R6 rd not strobe", int'(data_oe), 0);
    rd_n = 1'b1;
    wait_clk(4);
    strobe(1'b1, 5, 0, 1'b1, "R6 wr byte0");
    strobe(1'b1, 5, 1, 1'b1, "R6 wr byte1");
    chk(dma_req_n == 1'b1, "R8 dir eom", int'(dma_req_n), 1);
    dma_ack_n = 1'b1;
  endtask

  task automatic t_back2back;
    int r0;
    load(3, 2, 2);
    cfg_write(8'h43);
    wait_clk(3);
    dma_ack_n = 1'b0;
    r0 = req_rises;
    strobe(1'b0, 3, 0, 1'b1, "R8 m1 b0");
    strobe(1'b0, 3, 1, 1'b1, "R8 m1 b1");
    chk(req_rises == r0 + 1, "R8 req released", req_rises, r0 + 1);
    chk(dma_req_n == 1'b0, "R8 req re-raised", int'(dma_req_n), 0);
    strobe(1'b0, 3, 0, 1'b1, "R8 m2 b0");
    strobe(1'b0, 3, 1, 1'b1, "R8 m2 b1");
    chk(dma_req_n == 1'b1, "R8 no more msgs", int'(dma_req_n), 1);
    dma_ack_n = 1'b1;
  endtask

  task automatic t_restart_edge;
    load(4, 4, 1);
    cfg_write(8'h44);
    wait_clk(3);
    dma_ack_n = 1'b0;
    strobe(1'b0, 4, 0, 1'b1, "R2 b0");
    cfg_write(8'hC4);
    chk(dma_req_n == 1'b1, "R2 edge drops req", int'(dma_req_n), 1);
    wait_clk(3);
    chk(dma_req_n == 1'b0, "R2 re-request", int'(dma_req_n), 0);
    cfg_write(8'hC4);
    chk(dma_req_n == 1'b0, "R2 held bit no effect", int'(dma_req_n), 0);
    strobe(1'b0, 4, 1, 1'b1, "R2 b1");
    cfg_write(8'h44);
    chk(dma_req_n == 1'b0, "R2 clear no effect", int'(dma_req_n), 0);
    strobe(1'b0, 4, 2, 1'b1, "R2 b2");
    strobe(1'b0, 4, 3, 1'b1, "R2 b3");
    chk(dma_req_n == 1'b1, "R2 done", int'(dma_req_n), 1);
    dma_ack_n = 1'b1;
  endtask

  task automatic t_disable_abort;
    load(7, 3, 1);
    cfg_write(8'h47);
    wait_clk(3);
    dma_ack_n = 1'b0;
    strobe(1'b0, 7, 0, 1'b1, "R9 b0");
    cfg_write(8'h07);
    chk(dma_req_n == 1'b1, "R9 disable drops req", int'(dma_req_n), 1);
    strobe(1'b0, 7, 1, 1'b0, "R9 strobe after disable");
    dma_ack_n = 1'b1;
    m_left[7] = 0;
  endtask

  task automatic t_chan_switch;
    load(2, 2, 1);
    load(6, 2, 1);
    cfg_write(8'h42);
    wait_clk(3);
    dma_ack_n = 1'b0;
    strobe(1'b0, 2, 0, 1'b1, "R10 ch2 b0");
    cfg_write(8'h46);
    chk(dma_req_n == 1'b0, "R10 req kept", int'(dma_req_n), 0);
    strobe(1'b0, 2, 1, 1'b1, "R10 ch2 b1 after switch");
    chk(pops[6] == 0, "R11 no pop on ch6 yet", pops[6], 0);
    chk(dma_req_n == 1'b0, "R10 ch6 requested", int'(dma_req_n), 0);
    strobe(1'b0, 6, 0, 1'b1, "R10 ch6 b0");
    strobe(1'b0, 6, 1, 1'b1, "R10 ch6 b1");
    chk(pops[6] == 2, "R11 ch6 pops", pops[6], 2);
    chk(pops[0] == 0, "R11 ch0 untouched", pops[0], 0);
    dma_ack_n = 1'b1;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_idx[c] = 5'd0; m_len[c] = 1; m_left[c] = 0; pops[c] = 0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
    dma_ack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_cfg_fields();
    t_disabled();
    t_partial();
    t_ack_gate();
    t_dir_mode();
    t_back2back();
    t_restart_edge();
    t_disable_abort();
    t_chan_switch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule